// File: doc/BRIEF.md
# Temperature Event Output Controller

This block turns a stream of digital temperature samples into a single active-low event line of the open-drain kind: the block either pulls the line low or lets it go, and an external pull-up supplies the high level. Each sample is an 11-bit two's-complement word with a quarter-degree step, and it is qualified by a valid strobe. The block compares each sample with an upper limit, a lower limit and a critical limit. The critical limit has its own release hysteresis.

A small register port sets the limits and picks one of three event policies. In latching mode, a window crossing holds the line low until software acknowledges it. In tracking mode, the line follows the live out-of-window condition. In critical-only mode, only the critical limit counts. In every mode, the critical limit behaves as a tracking comparator with hysteresis. A global enable gates the line without stopping the status from updating, and a status register shows which conditions are present.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After a synchronous reset, `evt_pull_low` is 0. The control register (address 0) reads 0, which means disabled and latching mode. The upper, lower and critical limits (addresses 1, 2, 3) read 0x03FF. The hysteresis (address 4) and the status (address 5) read 0.
- R2: Latching mode (control bits [2:1] = 0). A valid sample above the upper limit or below the lower limit sets a latch. The latch holds the line low through later in-window samples. It clears only when software writes a 1 to status bit 3, and the line then releases. The latch is readable as status bit 3.
- R3: Tracking mode (control bits [2:1] = 1, and also code 3). The line is low exactly while the last valid sample is above the upper limit, below the lower limit, or in the critical state.
- R4: Critical state. It is set by a valid sample strictly above the critical limit. It is cleared by a valid sample strictly below (critical − hysteresis). Samples in between leave it unchanged. It drives the line in every mode and never sets the latch. It is readable as status bit 2.
- R5: Critical-only mode (control bits [2:1] = 2). The line is low only in the critical state. Upper and lower crossings have no effect on the line.
- R6: In critical-only mode, an asserted line stays low while samples lie between (critical − hysteresis) and the critical limit. It releases on the first sample below that band.
- R7: When control bit 0 (enable) is 0, the line is released. Status bits 0 (above upper) and 1 (below lower) and the critical state still follow each valid sample.
- R8: Writing 1 to status bit 3 in tracking or critical-only mode leaves the line unchanged. Other writes to the status address change nothing.
- R9: Samples are compared as signed values, so negative temperatures order correctly. A cycle with the valid strobe low changes neither the status nor the line.
- R10: Limits read back sign-extended to 16 bits. Hysteresis is unsigned and reads back zero-extended. The control register reads back {mode, enable} in bits [2:0].
- R11: The line and the status take their new value on the same clock edge that samples a valid word. They are unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Qualifies `temp_in` for one cycle |
| temp_in | input | 11 | Signed temperature, 0.25 °C per LSB |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data at `reg_addr` |
| evt_pull_low | output | 1 | 1 = drive the event line low, 0 = release it |

## Verification
The assertions check on every cycle the rules that hold in any context. The comparator state must not move without a valid strobe. A sample above the critical limit must enter the critical state, and the critical state must hold until a sample falls below the release point. The latch must survive until it is cleared, and the clear must take effect. Latch bits must stay frozen outside latching mode. The line must stay released in critical-only mode whenever the critical state is absent. Only the bench's scenarios can show the following: the full signed ordering across the whole 11-bit range, the exact release point of the hysteresis band while moving up and down, the interaction of enable and acknowledge writes with each policy, and the cycle on which the line changes.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

    parameter int TEMP_W = 11;
    parameter int REG_W  = 16;
    parameter int ADDR_W = 3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_MODE_LO = 1;
    localparam int CTRL_MODE_HI = 2;
    localparam int STAT_ACK_BIT = 3;

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic        [TEMP_W-1:0] hyst_t;

    localparam temp_t TEMP_MAX = {1'b0, {(TEMP_W-1){1'b1}}};

    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_TRACK = 2'd1,
        MODE_CRIT  = 2'd2,
        MODE_SPARE = 2'd3
    } evt_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_HIGH = 3'd1,
        A_LOW  = 3'd2,
        A_CRIT = 3'd3,
        A_HYST = 3'd4,
        A_STAT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        temp_t high;
        temp_t low;
        temp_t crit;
        hyst_t hyst;
    } limits_t;

    typedef struct packed {
        logic latched;
        logic crit;
        logic below;
        logic above;
    } status_t;

    function automatic logic [REG_W-1:0] sext_temp(temp_t v);
        return {{(REG_W-TEMP_W){v[TEMP_W-1]}}, v};
    endfunction

    function automatic logic [REG_W-1:0] zext_hyst(hyst_t v);
        return {{(REG_W-TEMP_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/tae_regs.sv
module tae_regs
    import thermal_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  status_t           status,
    output logic [REG_W-1:0]  rdata,
    output limits_t           limits,
    output evt_mode_e         mode,
    output logic              enable,
    output logic              ack_pulse
);

    logic unused_wbits;
    assign unused_wbits = ^wdata[REG_W-1:TEMP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            limits.high <= TEMP_MAX;
            limits.low  <= TEMP_MAX;
            limits.crit <= TEMP_MAX;
            limits.hyst <= '0;
            mode        <= MODE_LATCH;
            enable      <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    enable <= wdata[CTRL_EN_BIT];
                    mode   <= evt_mode_e'(wdata[CTRL_MODE_HI:CTRL_MODE_LO]);
                end
                A_HIGH:  limits.high <= temp_t'(wdata[TEMP_W-1:0]);
                A_LOW:   limits.low  <= temp_t'(wdata[TEMP_W-1:0]);
                A_CRIT:  limits.crit <= temp_t'(wdata[TEMP_W-1:0]);
                A_HYST:  limits.hyst <= wdata[TEMP_W-1:0];
                default: ;
            endcase
        end
    end

    assign ack_pulse = wr_en && (addr == A_STAT) && wdata[STAT_ACK_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[CTRL_MODE_HI:0] = {mode, enable};
            A_HIGH:  rdata = sext_temp(limits.high);
            A_LOW:   rdata = sext_temp(limits.low);
            A_CRIT:  rdata = sext_temp(limits.crit);
            A_HYST:  rdata = zext_hyst(limits.hyst);
            A_STAT:  rdata[$bits(status_t)-1:0] = status;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/tae_compare.sv
module tae_compare
    import thermal_alert_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  temp_t   temp,
    input  limits_t limits,
    output logic    win_hit,
    output logic    above_q,
    output logic    below_q,
    output logic    crit_q
);

    localparam int EXT_W = TEMP_W + 2;

    logic signed [EXT_W-1:0] temp_x;
    logic signed [EXT_W-1:0] release_x;
    logic                    over_high;
    logic                    under_low;
    logic                    hot;
    logic                    cool;

    assign over_high = $signed(temp) > $signed(limits.high);
    assign under_low = $signed(temp) < $signed(limits.low);
    assign hot       = $signed(temp) > $signed(limits.crit);

    assign temp_x    = {{2{temp[TEMP_W-1]}}, temp};
    assign release_x = $signed({{2{limits.crit[TEMP_W-1]}}, limits.crit})
                     - $signed({2'b00, limits.hyst});
    assign cool      = temp_x < release_x;

    assign win_hit   = valid && (over_high || under_low);

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q <= 1'b0;
            below_q <= 1'b0;
            crit_q  <= 1'b0;
        end else if (valid) begin
            above_q <= over_high;
            below_q <= under_low;
            if (hot)
                crit_q <= 1'b1;
            else if (cool)
                crit_q <= 1'b0;
        end
    end

    // R9: nothing moves without a valid sample
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable({above_q, below_q, crit_q}));

    // R4: a sample above the critical limit enters the critical state
    p_crit_enter_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && hot) |=> crit_q);

    // R6: the critical state holds inside the hysteresis band
    p_crit_band_r6: assert property (@(posedge clk) disable iff (rst)
        (crit_q && !(valid && cool)) |=> crit_q);

endmodule

// File: rtl/tae_policy.sv
module tae_policy
    import thermal_alert_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_mode_e mode,
    input  logic      enable,
    input  logic      ack_pulse,
    input  logic      win_hit,
    input  logic      above_q,
    input  logic      below_q,
    input  logic      crit_q,
    output logic      latch_q,
    output logic      pull_low
);

    logic evt_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else if (mode == MODE_LATCH) begin
            if (win_hit)
                latch_q <= 1'b1;
            else if (ack_pulse)
                latch_q <= 1'b0;
        end
    end

    always_comb begin
        case (mode)
            MODE_LATCH: evt_active = latch_q || crit_q;
            MODE_CRIT:  evt_active = crit_q;
            default:    evt_active = above_q || below_q || crit_q;
        endcase
    end

    assign pull_low = enable && evt_active;

    // R2: the latch survives until acknowledged
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH && latch_q && !ack_pulse) |=> latch_q);

    // R2: an acknowledge without a new crossing clears the latch
    p_latch_ack_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH && ack_pulse && !win_hit) |=> !latch_q);

    // R8: outside latching mode the latch is frozen
    p_ack_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_LATCH) |=> $stable(latch_q));

endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
    import thermal_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              evt_pull_low
);

    limits_t   limits;
    evt_mode_e mode;
    logic      enable;
    logic      ack_pulse;
    logic      win_hit;
    logic      above_q;
    logic      below_q;
    logic      crit_q;
    logic      latch_q;
    status_t   status;

    assign status = '{latched: latch_q, crit: crit_q, below: below_q, above: above_q};

    tae_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .status    (status),
        .rdata     (reg_rdata),
        .limits    (limits),
        .mode      (mode),
        .enable    (enable),
        .ack_pulse (ack_pulse)
    );

    tae_compare u_compare (
        .clk     (clk),
        .rst     (rst),
        .valid   (temp_valid),
        .temp    (temp_t'(temp_in)),
        .limits  (limits),
        .win_hit (win_hit),
        .above_q (above_q),
        .below_q (below_q),
        .crit_q  (crit_q)
    );

    tae_policy u_policy (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .enable    (enable),
        .ack_pulse (ack_pulse),
        .win_hit   (win_hit),
        .above_q   (above_q),
        .below_q   (below_q),
        .crit_q    (crit_q),
        .latch_q   (latch_q),
        .pull_low  (evt_pull_low)
    );

    // R5: in critical-only mode the line stays released without the critical state
    p_crit_only_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CRIT && !crit_q) |-> !evt_pull_low);

endmodule

// File: tb/test_thermal_alert_ctrl.sv
`timescale 1ns/1ps
module test_thermal_alert_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        temp_valid = 1'b0;
    logic [10:0] temp_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        evt_pull_low;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic m_en = 0, m_above = 0, m_below = 0, m_crit = 0, m_latch = 0;
    int   m_mode = 0;
    int   m_hi = 1023, m_lo = 1023, m_cl = 1023, m_hy = 0;

    always #2 clk = ~clk;

    thermal_alert_ctrl i_thermal_alert_ctrl (
        .clk          (clk),
        .rst          (rst),
        .temp_valid   (temp_valid),
        .temp_in      (temp_in),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .evt_pull_low (evt_pull_low)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_out();
        logic a;
        case (m_mode)
            0:       a = m_latch | m_crit;
            2:       a = m_crit;
            default: a = m_above | m_below | m_crit;
        endcase
        return m_en & a;
    endfunction

    function automatic logic [15:0] exp_stat();
        return {12'd0, m_latch, m_crit, m_below, m_above};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd5;
        case (a)
            3'd0: begin m_en = d[0]; m_mode = int'(d[2:1]); end
            3'd1: m_hi = int'($signed(d[10:0]));
            3'd2: m_lo = int'($signed(d[10:0]));
            3'd3: m_cl = int'($signed(d[10:0]));
            3'd4: m_hy = int'(d[10:0]);
            3'd5: if (m_mode == 0 && d[3]) m_latch = 1'b0;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
        reg_addr = 3'd5;
        #0.5;
    endtask

    task automatic model_sample(input int t);
        m_above = (t > m_hi);
        m_below = (t < m_lo);
        if (t > m_cl) m_crit = 1'b1;
        else if (t < m_cl - m_hy) m_crit = 1'b0;
        if (m_mode == 0 && (m_above || m_below)) m_latch = 1'b1;
    endtask

    task automatic apply(input int t, input logic v, input string tag);
        @(negedge clk);
        temp_valid = v; temp_in = 11'(t);
        @(negedge clk);
        temp_valid = 1'b0;
        if (v) model_sample(t);
        chk({tag, " line"}, {15'd0, evt_pull_low}, {15'd0, exp_out()});
        chk({tag, " status"}, reg_rdata, exp_stat());
    endtask

    task automatic check_line(input string tag);
        chk(tag, {15'd0, evt_pull_low}, {15'd0, exp_out()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 line", {15'd0, evt_pull_low}, 16'd0);
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd1, v); chk("R1 high", v, 16'h03FF);
        rd(3'd2, v); chk("R1 low", v, 16'h03FF);
        rd(3'd3, v); chk("R1 crit", v, 16'h03FF);
        rd(3'd4, v); chk("R1 hyst", v, 16'h0000);
        rd(3'd5, v); chk("R1 status", v, 16'h0000);

        // R10: readback formats
        wr(3'd1, 16'd80);
        wr(3'd2, 16'hFFD8);
        wr(3'd3, 16'd200);
        wr(3'd4, 16'd20);
        rd(3'd1, v); chk("R10 high", v, 16'h0050);
        rd(3'd2, v); chk("R10 low sign", v, 16'hFFD8);
        rd(3'd3, v); chk("R10 crit", v, 16'h00C8);
        rd(3'd4, v); chk("R10 hyst", v, 16'h0014);
        wr(3'd5, 16'h0007);
        rd(3'd5, v); chk("R8 status write ignored", v, 16'h0000);

        // R3 R4 R9: tracking mode, full signed sweep up then down
        wr(3'd0, 16'h0003);
        rd(3'd0, v); chk("R10 ctrl", v, 16'h0003);
        for (int t = -1024; t <= 1023; t++) apply(t, 1'b1, "R3 sweep up");
        for (int t = 1023; t >= -1024; t--) apply(t, 1'b1, "R9 sweep down");

        // R9: strobe low leaves everything as is
        apply(0, 1'b1, "R3 in window");
        apply(1000, 1'b0, "R9 no strobe");
        apply(-1000, 1'b0, "R9 no strobe neg");

        // R2: latching mode
        wr(3'd0, 16'h0001);
        check_line("R2 enter latching");
        apply(100, 1'b1, "R2 set above");
        apply(0, 1'b1, "R2 hold in window");
        apply(10, 1'b1, "R2 hold again");
        wr(3'd5, 16'h0008);
        check_line("R2 ack releases");
        apply(-50, 1'b1, "R2 set below");
        wr(3'd5, 16'h0008);
        check_line("R2 ack below");
        apply(-60, 1'b1, "R2 relatch");
        wr(3'd5, 16'h0008);
        apply(0, 1'b1, "R2 cleared window");

        // R4: critical state is tracking even in latching mode
        wr(3'd1, 16'h03FF);
        wr(3'd2, 16'hFC00);
        apply(250, 1'b1, "R4 crit in latching");
        apply(190, 1'b1, "R4 band hold");
        apply(180, 1'b1, "R4 band edge hold");
        apply(179, 1'b1, "R4 release");
        apply(190, 1'b1, "R4 band from below");

        // R5 R6: critical-only mode
        wr(3'd1, 16'd80);
        wr(3'd2, 16'hFFD8);
        wr(3'd0, 16'h0005);
        apply(100, 1'b1, "R5 above high ignored");
        apply(-500, 1'b1, "R5 below low ignored");
        for (int t = 150; t <= 230; t++) apply(t, 1'b1, "R6 rise");
        for (int t = 230; t >= 140; t--) apply(t, 1'b1, "R6 fall");

        // R8: acknowledge inert outside latching mode
        apply(250, 1'b1, "R8 crit set");
        wr(3'd5, 16'h0008);
        check_line("R8 ack in critical-only");
        wr(3'd0, 16'h0003);
        apply(100, 1'b1, "R8 tracking above");
        wr(3'd5, 16'h0008);
        check_line("R8 ack in tracking");

        // R7: enable gates the line only
        wr(3'd0, 16'h0002);
        check_line("R7 disabled");
        apply(-100, 1'b1, "R7 status moves");
        wr(3'd0, 16'h0003);
        check_line("R7 reenabled");
        apply(0, 1'b1, "R7 back in window");

        // R11: change on the sampling edge, not before
        @(negedge clk);
        temp_valid = 1'b1; temp_in = 11'd100;
        #1;
        chk("R11 before edge", {15'd0, evt_pull_low}, 16'd0);
        @(posedge clk);
        #0.5;
        temp_valid = 1'b0;
        model_sample(100);
        chk("R11 after edge", {15'd0, evt_pull_low}, {15'd0, exp_out()});
        chk("R11 status after edge", reg_rdata, exp_stat());

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule